// File: doc/BRIEF.md
# Bus Machine-Cycle T-State Generator

This block turns one machine-cycle request from an instruction sequencer into clock-by-clock bus activity. The sequencer presents a cycle kind, an address and a write byte. The block steps through numbered T-states, one per clock. In those states it drives the address bus, the read and write strobes, the write data and an I/O-versus-memory select. For read kinds it captures the byte returned on the bus.

An opcode fetch takes four T-states. Its last state belongs to the processor's internal work, so no strobe is active and the address is not driven. Every other kind takes three T-states. A done pulse marks the final T-state. A request that is waiting during that state starts the next cycle at once, with no idle clock between the two cycles.

Top module: `tstate_bus_seq`

## Requirements
- R1: The kind codes are 0 for opcode fetch, 1 for memory read, 2 for memory write, 3 for I/O read and 4 for I/O write. A request carrying code 5, 6 or 7 starts no cycle, and `tstate` stays 0.
- R2: A valid request is taken at a rising edge when `tstate` is 0 (idle) or when `done` is high. `tstate` reads 1 (T1) in the clock that follows.
- R3: Each T-state lasts one clock. An opcode fetch runs T1 to T4. Memory and I/O cycles run T1 to T3. After the final state, `tstate` returns to 0 unless a new request was taken.
- R4: In T1, `bus_addr_oe` is high and `bus_addr` carries the requested address, while both strobes are low. The address stays on the bus, unchanged, through T3.
- R5: For opcode fetch, memory read and I/O read, `bus_rd` is high in T2 and T3 and low in every other state.
- R6: For memory write and I/O write, `bus_wr` and `bus_wdata_oe` are high in T2 and T3, with `bus_wdata` equal to the requested byte. At all other times they are low and `bus_wdata` is 0.
- R7: In T4 of an opcode fetch, no strobe is active and `bus_addr_oe` is low.
- R8: `bus_io` is high in T1 to T3 of the two I/O kinds and low at every other time.
- R9: `rdata` takes the value of `bus_rdata` at the edge that ends T3 of a read kind. Write cycles and idle clocks leave it unchanged.
- R10: `done` is high for exactly one clock, in the final T-state of each cycle.
- R11: A request presented in a T-state that is not final is ignored. The running cycle keeps its address, kind and length.
- R12: After reset, `tstate` is 0, every bus output and `done` are low, and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one period per T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request present |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Byte to write |
| bus_addr | output | AW | Address bus, 0 when not driven |
| bus_addr_oe | output | 1 | Address bus driven |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_io | output | 1 | High for I/O space, low for memory |
| bus_wdata | output | DW | Write data, 0 when not driven |
| bus_wdata_oe | output | 1 | Write data driven |
| bus_rdata | input | DW | Data returned by memory or I/O |
| tstate | output | 3 | Current T-state, 0 when idle |
| done | output | 1 | Final T-state of the current cycle |
| rdata | output | DW | Last byte captured by a read kind |

## Verification
The assertions assume that the kind held for a running cycle is one of the five legal codes. The block only latches a legal code, so that assumption rests on its own accept logic. It does not rest on what the sequencer sends. The assertions also assume that `bus_rdata` only needs to be valid at the edge that ends T3. The stimulus changes requests and read data only on falling edges. The bench drives illegal codes and requests during busy states on purpose, to show that they are refused. It sets `bus_rdata` to a junk value in T1, T2 and the idle clocks, so that only a capture in T3 yields the expected byte.

// File: rtl/busc_pkg.sv
package busc_pkg;

    localparam int unsigned TS_W      = 3;
    localparam int unsigned STB_FIRST = 2;
    localparam int unsigned XFER_TS   = 3;
    localparam int unsigned FETCH_TS  = XFER_TS + 1;

    typedef enum logic [2:0] {
        CYC_OPFETCH = 3'd0,
        CYC_MEMRD   = 3'd1,
        CYC_MEMWR   = 3'd2,
        CYC_IORD    = 3'd3,
        CYC_IOWR    = 3'd4
    } cyc_kind_e;

    function automatic logic kind_legal(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic kind_reads(input cyc_kind_e k);
        return (k == CYC_OPFETCH) || (k == CYC_MEMRD) || (k == CYC_IORD);
    endfunction

    function automatic logic kind_writes(input cyc_kind_e k);
        return (k == CYC_MEMWR) || (k == CYC_IOWR);
    endfunction

    function automatic logic kind_io(input cyc_kind_e k);
        return (k == CYC_IORD) || (k == CYC_IOWR);
    endfunction

    function automatic logic [TS_W-1:0] kind_len(input cyc_kind_e k);
        return (k == CYC_OPFETCH) ? TS_W'(FETCH_TS) : TS_W'(XFER_TS);
    endfunction

endpackage

// File: rtl/busc_tctr.sv
module busc_tctr #(
    parameter int unsigned TSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [TSW-1:0] last_ts,
    output logic [TSW-1:0] ts,
    output logic           final_ts
);

    typedef struct packed {
        logic [TSW-1:0] ts;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        final_ts = (st_q.ts != '0) && (st_q.ts == last_ts);
        if ((st_q.ts == '0) || final_ts) begin
            st_d.ts = start ? TSW'(1) : '0;
        end else begin
            st_d.ts = st_q.ts + TSW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ts = st_q.ts;

    // R3
    ts_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ts != '0) |-> (st_q.ts <= last_ts));

    // R3
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ts != '0) && !final_ts) |=> (st_q.ts == $past(st_q.ts) + TSW'(1)));

endmodule

// File: rtl/busc_phase.sv
module busc_phase
    import busc_pkg::*;
(
    input  logic [TS_W-1:0] ts,
    input  cyc_kind_e       kind,
    output logic            addr_oe,
    output logic            rd_stb,
    output logic            wr_stb,
    output logic            io_sel,
    output logic            wdata_oe
);

    logic xfer_win;
    logic stb_win;

    always_comb begin
        xfer_win = (ts >= TS_W'(1)) && (ts <= TS_W'(XFER_TS));
        stb_win  = (ts >= TS_W'(STB_FIRST)) && (ts <= TS_W'(XFER_TS));
        addr_oe  = xfer_win;
        io_sel   = xfer_win && kind_io(kind);
        rd_stb   = stb_win && kind_reads(kind);
        wr_stb   = stb_win && kind_writes(kind);
        wdata_oe = wr_stb;
    end

endmodule

// File: rtl/busc_rdcap.sv
module busc_rdcap #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    typedef struct packed {
        logic [DW-1:0] val;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.val = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.val;

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(dout));

endmodule

// File: rtl/tstate_bus_seq.sv
module tstate_bus_seq
    import busc_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_addr_oe,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_io,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wdata_oe,
    input  logic [DW-1:0] bus_rdata,
    output logic [2:0]    tstate,
    output logic          done,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        cyc_kind_e     kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } cyc_req_t;

    cyc_req_t        req_d, req_q;
    logic            accept;
    logic [TS_W-1:0] ts;
    logic [TS_W-1:0] last_ts;
    logic            final_ts;
    logic            addr_oe, rd_stb, wr_stb, io_sel, wdata_oe;
    logic            capture;

    always_comb begin
        last_ts = kind_len(req_q.kind);
        accept  = req_valid && kind_legal(req_kind) && ((ts == '0) || final_ts);
        req_d   = req_q;
        if (accept) begin
            req_d.kind  = cyc_kind_e'(req_kind);
            req_d.addr  = req_addr;
            req_d.wdata = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '{kind: CYC_OPFETCH, addr: '0, wdata: '0};
        end else begin
            req_q <= req_d;
        end
    end

    busc_tctr #(.TSW(TS_W)) u_tctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .last_ts  (last_ts),
        .ts       (ts),
        .final_ts (final_ts)
    );

    busc_phase u_phase (
        .ts       (ts),
        .kind     (req_q.kind),
        .addr_oe  (addr_oe),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .io_sel   (io_sel),
        .wdata_oe (wdata_oe)
    );

    assign capture = (ts == TS_W'(XFER_TS)) && kind_reads(req_q.kind);

    busc_rdcap #(.DW(DW)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (bus_rdata),
        .dout    (rdata)
    );

    assign bus_addr     = addr_oe ? req_q.addr : '0;
    assign bus_addr_oe  = addr_oe;
    assign bus_rd       = rd_stb;
    assign bus_wr       = wr_stb;
    assign bus_io       = io_sel;
    assign bus_wdata    = wdata_oe ? req_q.wdata : '0;
    assign bus_wdata_oe = wdata_oe;
    assign tstate       = 3'(ts);
    assign done         = final_ts;

    // R4
    t1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == 3'd1) |-> (bus_addr_oe && !bus_rd && !bus_wr));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == 3'd2) |=> ($stable(bus_addr) && bus_addr_oe));

    // R7
    fetch_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tstate == 3'd3) && (req_q.kind == CYC_OPFETCH)) |=>
        ((tstate == 3'd4) && !bus_rd && !bus_wr && !bus_addr_oe && done));

    // R5
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R8
    io_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_io |-> bus_addr_oe);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    start_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tstate == 3'd0) && req_valid && kind_legal(req_kind)) |=> (tstate == 3'd1));

endmodule

// File: tb/tstate_bus_seq_bench.sv
module tstate_bus_seq_bench;
    import busc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam logic [DW-1:0] JUNK = 8'hEE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_kind = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [AW-1:0] bus_addr;
    logic          bus_addr_oe, bus_rd, bus_wr, bus_io, bus_wdata_oe;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = JUNK;
    logic [2:0]    tstate;
    logic          done;
    logic [DW-1:0] rdata;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tstate_bus_seq #(.AW(AW), .DW(DW)) u_tstate_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .bus_addr(bus_addr),
        .bus_addr_oe(bus_addr_oe), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_io(bus_io),
        .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata),
        .tstate(tstate), .done(done), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Checks one T-state at the falling edge, from the requirements alone.
    task automatic chk_state(input logic [2:0] k, input int t, input int len,
                             input logic [AW-1:0] a, input logic [DW-1:0] wd);
        bit rd_k = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
        bit wr_k = (k == 3'd2) || (k == 3'd4);
        bit io_k = (k == 3'd3) || (k == 3'd4);
        bit xfer = (t >= 1) && (t <= 3);
        bit stb  = (t == 2) || (t == 3);
        logic [5:0] exp_v = {xfer, stb && rd_k, stb && wr_k, xfer && io_k, stb && wr_k, t == len};
        logic [5:0] act_v = {bus_addr_oe, bus_rd, bus_wr, bus_io, bus_wdata_oe, done};
        chk(tstate == 3'(t), "R3 tstate", 32'(tstate), 32'(t));
        chk(act_v == exp_v, "R4/R5/R6/R7/R8/R10 strobes", 32'(act_v), 32'(exp_v));
        chk(bus_addr == (xfer ? a : '0), "R4 address", 32'(bus_addr), 32'(xfer ? a : '0));
        chk(bus_wdata == ((stb && wr_k) ? wd : '0), "R6 write data",
            32'(bus_wdata), 32'((stb && wr_k) ? wd : '0));
    endtask

    // Runs one full cycle from idle and checks every T-state and the capture.
    task automatic run_cycle(input logic [2:0] k, input logic [AW-1:0] a,
                             input logic [DW-1:0] wd, input logic [DW-1:0] rv);
        int len = (k == 3'd0) ? 4 : 3;
        bit rd_k = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
        logic [DW-1:0] old_r = rdata;
        @(negedge clk);
        req_valid = 1; req_kind = k; req_addr = a; req_wdata = wd;
        for (int t = 1; t <= len; t++) begin
            @(negedge clk);
            req_valid = 0;
            bus_rdata = (t == 3) ? rv : JUNK;
            chk_state(k, t, len, a, wd);
        end
        @(negedge clk);
        bus_rdata = JUNK;
        chk(tstate == 3'd0, "R3 idle after cycle", 32'(tstate), 0);
        chk(rdata == (rd_k ? rv : old_r), "R9 captured byte", 32'(rdata), 32'(rd_k ? rv : old_r));
    endtask

    task automatic test_reset();
        chk({bus_addr_oe, bus_rd, bus_wr, bus_io, bus_wdata_oe, done} == 6'b0,
            "R12 outputs low", 32'({bus_addr_oe, bus_rd, bus_wr, bus_io, bus_wdata_oe, done}), 0);
        chk(tstate == 3'd0, "R12 tstate", 32'(tstate), 0);
        chk(rdata == '0, "R12 rdata", 32'(rdata), 0);
        chk(bus_addr == '0 && bus_wdata == '0, "R12 buses", 32'({bus_addr, bus_wdata}), 0);
    endtask

    task automatic test_illegal();
        @(negedge clk);
        req_valid = 1; req_kind = 3'd6; req_addr = 16'h1234;
        @(negedge clk);
        chk(tstate == 3'd0, "R1 code 6 ignored", 32'(tstate), 0);
        req_kind = 3'd7;
        @(negedge clk);
        chk(tstate == 3'd0 && !bus_addr_oe, "R1 code 7 ignored", 32'(tstate), 0);
        req_valid = 0;
    endtask

    task automatic test_busy_ignore();
        @(negedge clk);
        req_valid = 1; req_kind = 3'd1; req_addr = 16'h2222; req_wdata = 8'h00;
        @(negedge clk);
        req_kind = 3'd0; req_addr = 16'h9999;
        chk(tstate == 3'd1, "R11 T1", 32'(tstate), 1);
        @(negedge clk);
        chk(bus_addr == 16'h2222, "R11 address kept", 32'(bus_addr), 32'h2222);
        req_valid = 0;
        bus_rdata = 8'h5C;
        @(negedge clk);
        chk(tstate == 3'd3 && done, "R11 length kept", 32'({tstate, done}), 32'({3'd3, 1'b1}));
        @(negedge clk);
        bus_rdata = JUNK;
        chk(tstate == 3'd0, "R11 returns idle", 32'(tstate), 0);
        chk(rdata == 8'h5C, "R11 capture of running read", 32'(rdata), 32'h5C);
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        req_valid = 1; req_kind = 3'd0; req_addr = 16'h41FF;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        @(negedge clk);
        bus_rdata = 8'h32;
        @(negedge clk);
        bus_rdata = JUNK;
        chk(tstate == 3'd4 && done, "R2 fetch final state", 32'({tstate, done}), 32'({3'd4, 1'b1}));
        req_valid = 1; req_kind = 3'd2; req_addr = 16'h526A; req_wdata = 8'hC7;
        @(negedge clk);
        req_valid = 0;
        chk(tstate == 3'd1, "R2 back-to-back T1", 32'(tstate), 1);
        chk(bus_addr == 16'h526A, "R2 new address", 32'(bus_addr), 32'h526A);
        chk(rdata == 8'h32, "R9 fetch byte", 32'(rdata), 32'h32);
        @(negedge clk);
        chk(bus_wr && bus_wdata == 8'hC7, "R6 write after fetch", 32'(bus_wdata), 32'hC7);
        @(negedge clk);
        @(negedge clk);
        chk(tstate == 3'd0 && rdata == 8'h32, "R9 write keeps rdata", 32'(rdata), 32'h32);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 2 + 2);
        test_reset();
        rst_n = 1;
        @(negedge clk);
        test_reset();
        run_cycle(3'd0, 16'h4105, 8'h00, 8'h34);
        run_cycle(3'd1, 16'h4250, 8'h00, 8'h12);
        run_cycle(3'd2, 16'h4250, 8'h13, 8'hA5);
        run_cycle(3'd3, 16'h0080, 8'h00, 8'h7E);
        run_cycle(3'd4, 16'h0081, 8'h3C, 8'h11);
        test_illegal();
        test_busy_ignore();
        test_back_to_back();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule